// File: doc/BRIEF.md
# Host Register Access Port with Indirect Pointer

This block sits between a host processor bus and the register file of a two-channel serial controller. Everything in it runs on the controller clock. The host drives four asynchronous active-low strobes: chip enable, write, read and interrupt acknowledge. Along with them it drives a channel select, a control/data select and an 8-bit data byte. The block synchronizes the strobes and recognizes complete bus cycles. It turns each valid write into one item on a valid/ready register-file write port, and it drives read data or an interrupt vector back onto the data bus.

Control registers are reached indirectly. Each channel owns a 4-bit pointer that rests at zero. A control write made while the pointer is zero does not reach the register file: it only loads the pointer from the low nibble of the data byte. The following control access uses that pointer, and the pointer returns to zero once that access has completed. Data accesses never touch the pointers.

While the synchronized interrupt-acknowledge strobe is low, the chip enable, write, channel select and control/data select inputs are ignored, and a read strobe in that time places the vector byte on the bus.

The write port applies back-pressure in the usual way. Once `wr_valid` rises, the item stays unchanged until a cycle in which `wr_ready` is high. A host write cycle that completes while an item is still waiting is dropped, and the block does not buffer it.

Top module: `bus_access_unit`

## Requirements
- R1: A write is taken only if `ce_n` stays low and `iack_n` stays high for the whole synchronized low phase of `wr_n`. A write strobe with chip enable high, or with chip enable released part way through, causes no register write and no pointer change.
- R2: Channel select, control/data select and data are taken from the last cycle before the synchronized `wr_n` rises, so a data byte that settles after `wr_n` falls is written correctly.
- R3: A data write (`dc_sel`=1) issues address 16 (bit 4 set, pointer field zero) on the addressed channel and leaves both pointers unchanged.
- R4: A control write (`dc_sel`=0) made while the addressed channel's pointer is zero loads the pointer with `din[3:0]` and produces no write-port item.
- R5: A control write made while the pointer is nonzero issues address {1'b0, pointer} with the data byte. Once that item is accepted, the pointer is zero from the next cycle.
- R6: `wr_valid` stays high with `wr_chan`, `wr_addr` and `wr_data` unchanged until `wr_ready` is high. A host write completing in that time is dropped.
- R7: While the synchronized `iack_n` is low, no new write or read cycle is taken and neither pointer changes.
- R8: With the synchronized `iack_n` and `rd_n` both low, `doe` is 1 and `dout` equals `vec`, regardless of `ce_n`.
- R9: Outside acknowledge, with the synchronized `rd_n` and `ce_n` low, `doe` is 1 and `dout` shows `rd_data_a` (`chan_sel`=0) or `rd_data_b` (`chan_sel`=1). A completed control read returns that channel's pointer to zero.
- R10: In every other case `doe` is 0.
- R11: Synchronous reset (`rst_n` low at a clock edge) clears both pointers and `wr_valid`.
- R12: The two channel pointers are independent: loading or clearing one leaves the other unchanged.
- R13: `rd_addr` always shows 16 for a data select, or {1'b0, pointer of the channel chosen by `chan_sel`} for a control select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| iack_n | input | 1 | Interrupt acknowledge, active low, asynchronous |
| chan_sel | input | 1 | Channel select: 0 = channel A, 1 = channel B |
| dc_sel | input | 1 | 1 = data access, 0 = control access |
| din | input | 8 | Data bus in |
| dout | output | 8 | Data bus out |
| doe | output | 1 | Data bus output enable (bus tri-stated when 0) |
| vec | input | 8 | Interrupt vector byte |
| wr_valid | output | 1 | Register write item valid |
| wr_ready | input | 1 | Register file accepts item |
| wr_chan | output | 1 | Channel of the write item |
| wr_addr | output | 5 | Register address of the write item |
| wr_data | output | 8 | Data of the write item |
| rd_addr | output | 5 | Read address for the selected channel |
| rd_data_a | input | 8 | Read data from channel A registers |
| rd_data_b | input | 8 | Read data from channel B registers |

## Verification
The hardest state to reach from the ports is a write completing while an earlier item is still stalled on the write port. That needs a held-low `wr_ready` and two full host write cycles back to back. The bench parks `wr_ready` low across both cycles, then releases it and expects exactly one item to come out. Pointer contents have no direct output. The bench reads them at `rd_addr` with `dc_sel` low between bus cycles, and so confirms the cycles that had to be ignored (acknowledge active, chip enable missing or released early).

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int DW      = 8;
  localparam int PTR_W   = 4;
  localparam int ADDR_W  = PTR_W + 1;
  localparam int NCH     = 2;

  typedef struct packed {
    logic          ch;
    logic          dc;
    logic [DW-1:0] d;
  } bau_pins_t;

  typedef struct packed {
    logic              ch;
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0]     d;
  } bau_req_t;

  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1) << PTR_W;
endpackage

// File: rtl/bau_sync.sv
module bau_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/bau_strobe.sv
module bau_strobe
  import bau_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_s,
  input  logic      wr_s,
  input  logic      rd_s,
  input  logic      iack_s,
  input  bau_pins_t pins_d,
  output logic      wr_done,
  output logic      rd_done,
  output bau_pins_t hold
);
  logic wr_q, rd_q, wr_ok, rd_ok;
  logic bus_ok;

  // cycle stays valid only while chip enable is low and no acknowledge
  assign bus_ok = !ce_s && iack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      rd_q  <= 1'b1;
      wr_ok <= 1'b0;
      rd_ok <= 1'b0;
      hold  <= '0;
    end else begin
      wr_q <= wr_s;
      rd_q <= rd_s;
      if (wr_q && !wr_s)  wr_ok <= bus_ok;
      else if (!wr_s)     wr_ok <= wr_ok && bus_ok;
      if (rd_q && !rd_s)  rd_ok <= bus_ok;
      else if (!rd_s)     rd_ok <= rd_ok && bus_ok;
      // keep the latest settled pins while a strobe is low
      if ((!wr_s || !rd_s) && bus_ok) hold <= pins_d;
    end
  end

  assign wr_done = !wr_q && wr_s && wr_ok && iack_s;
  assign rd_done = !rd_q && rd_s && rd_ok && iack_s;
endmodule

// File: rtl/bau_ptr_bank.sv
module bau_ptr_bank
  import bau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   load_vec,
  input  logic [PTR_W-1:0] load_val,
  input  logic [NCH-1:0]   clr_vec,
  output logic [PTR_W-1:0] ptr [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)           ptr[c] <= '0;
      else if (clr_vec[c])  ptr[c] <= '0;
      else if (load_vec[c]) ptr[c] <= load_val;
    end
  end
endmodule

// File: rtl/bus_access_unit.sv
module bus_access_unit
  import bau_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              iack_n,
  input  logic              chan_sel,
  input  logic              dc_sel,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              doe,
  input  logic [DW-1:0]     vec,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_chan,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     rd_data_a,
  input  logic [DW-1:0]     rd_data_b
);
  localparam int PIN_W = $bits(bau_pins_t);

  logic [3:0]       strb_s;
  logic             ce_s, wr_s, rd_s, iack_s;
  bau_pins_t        pins_raw, pins_d, hold;
  logic             wr_done, rd_done;
  logic [PTR_W-1:0] ptr_q [NCH];
  logic [PTR_W-1:0] cur_ptr;
  logic             pend, take, issue, load_en, wclr, rclr;
  bau_req_t         req;
  logic [NCH-1:0]   load_vec, clr_vec;

  bau_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'hF)) u_strb_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n, wr_n, rd_n, iack_n}), .q(strb_s)
  );
  assign {ce_s, wr_s, rd_s, iack_s} = strb_s;

  // pins delayed by the same depth so they line up with the strobes
  assign pins_raw = '{ch: chan_sel, dc: dc_sel, d: din};
  bau_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST('0)) u_pin_dly (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_d)
  );

  bau_strobe u_strobe (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .wr_s(wr_s), .rd_s(rd_s), .iack_s(iack_s),
    .pins_d(pins_d), .wr_done(wr_done), .rd_done(rd_done), .hold(hold)
  );

  assign cur_ptr = ptr_q[hold.ch];
  assign take    = wr_done && !pend;
  assign load_en = take && !hold.dc && (cur_ptr == '0);
  assign issue   = take && (hold.dc || (cur_ptr != '0));
  assign wclr    = pend && wr_ready && !req.addr[PTR_W];
  assign rclr    = rd_done && !hold.dc;

  for (genvar c = 0; c < NCH; c++) begin : g_ctl
    assign load_vec[c] = load_en && (hold.ch == c[0]);
    assign clr_vec[c]  = (wclr && (req.ch == c[0])) || (rclr && (hold.ch == c[0]));
  end

  bau_ptr_bank u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .load_vec(load_vec), .load_val(hold.d[PTR_W-1:0]),
    .clr_vec(clr_vec), .ptr(ptr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      req  <= '0;
    end else if (issue) begin
      pend     <= 1'b1;
      req.ch   <= hold.ch;
      req.addr <= hold.dc ? DATA_ADDR : {1'b0, cur_ptr};
      req.d    <= hold.d;
    end else if (pend && wr_ready) begin
      pend <= 1'b0;
    end
  end

  assign wr_valid = pend;
  assign wr_chan  = req.ch;
  assign wr_addr  = req.addr;
  assign wr_data  = req.d;

  assign rd_addr = dc_sel ? DATA_ADDR : {1'b0, ptr_q[chan_sel]};

  always_comb begin
    if (!iack_s) begin
      doe  = !rd_s;
      dout = vec;
    end else begin
      doe  = !rd_s && !ce_s;
      dout = chan_sel ? rd_data_b : rd_data_a;
    end
  end
endmodule

// File: rtl/bau_checker.sv
module bau_checker
  import bau_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_chan,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              iack_s,
  input logic [PTR_W-1:0]  ptr_a,
  input logic [PTR_W-1:0]  ptr_b
);
  // R6
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid);

  // R6
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_addr) && $stable(wr_data) && $stable(wr_chan));

  // R5
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !wr_addr[PTR_W] |=>
      (($past(wr_chan) ? ptr_b : ptr_a) == '0));

  // R7
  no_ack_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(iack_s));

  // R11
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> !wr_valid && ptr_a == '0 && ptr_b == '0);
endmodule

bind bus_access_unit bau_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_chan(wr_chan),
  .wr_addr(wr_addr), .wr_data(wr_data), .iack_s(iack_s),
  .ptr_a(ptr_q[0]), .ptr_b(ptr_q[1])
);

// File: tb/tb_bus_access_unit.sv
module tb_bus_access_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, iack_n = 1'b1;
  logic       chan_sel = 1'b0, dc_sel = 1'b0;
  logic [7:0] din = 8'h00, vec = 8'h5A;
  logic [7:0] dout;
  logic       doe, wr_valid, wr_chan;
  logic       wr_ready = 1'b1;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] rd_data_a, rd_data_b;

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_q [$];

  always #4 clk = ~clk;

  assign rd_data_a = {3'b101, rd_addr};
  assign rd_data_b = {3'b011, rd_addr} ^ 8'h0F;

  bus_access_unit dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
    .iack_n(iack_n), .chan_sel(chan_sel), .dc_sel(dc_sel), .din(din),
    .dout(dout), .doe(doe), .vec(vec), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_chan(wr_chan), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data_a(rd_data_a),
    .rd_data_b(rd_data_b)
  );
  logic [7:0] wr_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      logic [13:0] got;
      got = {wr_chan, wr_addr, wr_data};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected write item", int'(got), 0);
      end else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R3/R5", "write item", int'(got), int'(e));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full host write; data settles two cycles after the strobe falls (R2)
  task automatic bus_write(input logic ch, input logic dc, input logic [7:0] d,
                           input bit ce_low = 1'b1, input bit ce_drop = 1'b0);
    @(negedge clk);
    chan_sel = ch; dc_sel = dc; din = ~d; wr_n = 1'b0; ce_n = !ce_low;
    idle(2);
    din = d;
    idle(1);
    if (ce_drop) ce_n = 1'b1;
    idle(2);
    wr_n = 1'b1; ce_n = 1'b1;
    din = 8'hEE;
    idle(6);
  endtask

  task automatic push_exp(input logic ch, input logic [4:0] a, input logic [7:0] d);
    exp_q.push_back({ch, a, d});
  endtask

  task automatic check_ptr(input logic ch, input logic [3:0] e, input string req);
    @(negedge clk);
    chan_sel = ch; dc_sel = 1'b0;
    #1;
    chk(rd_addr == {1'b0, e}, req, "pointer via rd_addr", int'(rd_addr), int'({1'b0, e}));
  endtask

  // host read; checks doe and dout while the strobe is seen low
  task automatic bus_read(input logic ch, input logic dc, input logic [7:0] e, input string req);
    @(negedge clk);
    chan_sel = ch; dc_sel = dc; ce_n = 1'b0; rd_n = 1'b0;
    idle(4);
    chk(doe == 1'b1, req, "read doe", int'(doe), 1);
    chk(dout == e, req, "read dout", int'(dout), int'(e));
    rd_n = 1'b1; ce_n = 1'b1;
    idle(6);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 0, 1);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R11 reset state
    chk(wr_valid == 1'b0, "R11", "wr_valid after reset", int'(wr_valid), 0);
    chk(doe == 1'b0, "R10", "doe idle", int'(doe), 0);
    check_ptr(1'b0, 4'd0, "R11");
    check_ptr(1'b1, 4'd0, "R11");

    // R4 load pointer A with 5, no item
    bus_write(1'b0, 1'b0, 8'hF5);
    check_ptr(1'b0, 4'd5, "R4");
    check_ptr(1'b1, 4'd0, "R12");
    // R13 data select address
    @(negedge clk); dc_sel = 1'b1; #1;
    chk(rd_addr == 5'd16, "R13", "data rd_addr", int'(rd_addr), 16);

    // R9 control read of A register 5, then pointer clears
    bus_read(1'b0, 1'b0, {3'b101, 5'd5}, "R9");
    check_ptr(1'b0, 4'd0, "R9");

    // R12 load B=3, then data write to B (R3)
    bus_write(1'b1, 1'b0, 8'h03);
    push_exp(1'b1, 5'd16, 8'h55);
    bus_write(1'b1, 1'b1, 8'h55);
    check_ptr(1'b1, 4'd3, "R3");
    check_ptr(1'b0, 4'd0, "R12");

    // R5 load A=9 then control write
    bus_write(1'b0, 1'b0, 8'h09);
    push_exp(1'b0, 5'd9, 8'h3C);
    bus_write(1'b0, 1'b0, 8'h3C);
    check_ptr(1'b0, 4'd0, "R5");
    check_ptr(1'b1, 4'd3, "R12");
    // R5 on channel B (pointer 3) with late data
    push_exp(1'b1, 5'd3, 8'hA7);
    bus_write(1'b1, 1'b0, 8'hA7);
    check_ptr(1'b1, 4'd0, "R5");

    // R1 aborted cycles with pointer A = 4
    bus_write(1'b0, 1'b0, 8'h04);
    bus_write(1'b0, 1'b0, 8'h77, 1'b0);
    bus_write(1'b0, 1'b0, 8'h66, 1'b1, 1'b1);
    check_ptr(1'b0, 4'd4, "R1");

    // R7 and R8: acknowledge ignores write and drives vector
    @(negedge clk); iack_n = 1'b0;
    idle(3);
    bus_write(1'b0, 1'b0, 8'h99);
    check_ptr(1'b0, 4'd4, "R7");
    @(negedge clk); rd_n = 1'b0; ce_n = 1'b1;
    idle(4);
    chk(doe == 1'b1, "R8", "ack doe", int'(doe), 1);
    chk(dout == 8'h5A, "R8", "ack vector", int'(dout), 8'h5A);
    rd_n = 1'b1;
    idle(4);
    iack_n = 1'b1;
    idle(4);
    chk(doe == 1'b0, "R10", "doe after ack", int'(doe), 0);
    check_ptr(1'b0, 4'd4, "R7");

    // R9 channel B data read
    bus_read(1'b1, 1'b1, {3'b011, 5'd16} ^ 8'h0F, "R9");

    // R6 stall: first item held, second write dropped
    wr_ready = 1'b0;
    push_exp(1'b0, 5'd16, 8'h11);
    bus_write(1'b0, 1'b1, 8'h11);
    bus_write(1'b0, 1'b1, 8'h22);
    chk(wr_valid == 1'b1, "R6", "valid held under stall", int'(wr_valid), 1);
    chk(wr_data == 8'h11, "R6", "held data", int'(wr_data), 8'h11);
    @(negedge clk); wr_ready = 1'b1;
    idle(4);
    chk(wr_valid == 1'b0, "R6", "valid after accept", int'(wr_valid), 0);
    check_ptr(1'b0, 4'd4, "R3");

    idle(4);
    chk(exp_q.size() == 0, "R6", "items left in scoreboard", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule